// File: doc/BRIEF.md
# Per-Requester Grant Rate Throttle

This block sits in front of a crossbar arbiter and paces how often each of its requesting units may win a normal grant. Software holds one 4-bit rate code per unit in a 64-bit configuration word. A unit that has just been granted must sit out a number of cycles set by its code before it may win again. Holding back a unit's grants in this way applies backpressure to that unit's output queue.

Each cycle the block masks the raw request lines with per-unit eligibility. A round-robin picker then issues at most one normal grant, in the same cycle as the request. A separate vector of bypass grants passes straight through to its output and is never held back by the rate codes.

Top module: `gnt_throttle`

## Requirements
- R1: Reset clears every rate code, every pacing counter and the round-robin pointer. In the first cycle after reset every requesting unit is eligible, and the search starts at unit 0.
- R2: `gnt_o` has at most one bit set, in the same cycle as the request. That bit belongs to a unit whose `req_i` bit is high. When any requesting unit is eligible, exactly one grant is issued.
- R3: After a grant to unit i, the next search begins at unit i+1, wrapping from the last unit to unit 0.
- R4: The rate code of unit k occupies bits [4k+3:4k] of `cfg_data_i`. Bits 63:32 are ignored.
- R5: A code N from 1 to 13 makes a granted unit ineligible for the next N cycles. Its next grant can come no earlier than N+1 cycles after the previous one.
- R6: Code 0 lets a unit be granted in every cycle.
- R7: Code 0xF means the unit never receives a normal grant.
- R8: Code 0xE is the slowest rate. After a grant the unit waits SLOW_RELOAD cycles (default 63).
- R9: `byp_gnt_o` equals `byp_gnt_i` in the same cycle, whatever the rate codes are.
- R10: A write takes effect at the next clock edge. When a write changes a unit's code, that unit's counter is loaded from the new code at that edge. The unit is next eligible after that reload count of cycles. Units whose codes did not change keep their counters.
- R11: A unit whose wait has expired stays eligible until it is granted, even if it makes no request in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_i | input | 1 | Write strobe for the rate configuration word |
| cfg_data_i | input | 64 | Rate configuration word, 4 bits per unit in the low 32 bits |
| req_i | input | 8 | Raw request line per unit |
| byp_gnt_i | input | 8 | Bypass grant vector from the arbiter |
| gnt_o | output | 8 | One-hot normal grant |
| byp_gnt_o | output | 8 | Bypass grant vector, passed through unchanged |

## Verification
The hardest case to reach is a write that lands while a unit is counting down. The new code must replace the old one for that unit alone, and the configuration cannot be read back, so the effect has to show up through grant timing. The stimulus writes a code, then holds a single unit's request high cycle after cycle and counts the idle cycles before its grant. Runs with code 3, code 2 on the highest unit, and the slowest code measure the idle gap before each grant, both right after the write and after a previous grant. A further write switches one unit between the never code and a normal code while another unit keeps being granted.

// File: rtl/gth_pkg.sv
package gth_pkg;

    localparam int unsigned RATE_W = 4;

    // reserved rate codes
    localparam logic [RATE_W-1:0] RATE_NEVER   = 4'hF;
    localparam logic [RATE_W-1:0] RATE_SLOWEST = 4'hE;

    // number of blocked cycles that follow a grant for a given code
    function automatic int unsigned reload_count(
        input logic [RATE_W-1:0] code,
        input int unsigned       slow
    );
        if (code == RATE_NEVER)        return 0;
        else if (code == RATE_SLOWEST) return slow;
        else                           return int'(code);
    endfunction

endpackage

// File: rtl/gth_pace_cnt.sv
module gth_pace_cnt
    import gth_pkg::*;
#(
    parameter int unsigned SLOW_RELOAD = 63,
    localparam int unsigned CNT_W      = $clog2(SLOW_RELOAD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_cur_i,
    input  logic [RATE_W-1:0] rate_new_i,
    input  logic              rate_chg_i,
    input  logic              gnt_i,
    output logic              elig_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pace_st_t;

    pace_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (gnt_i || rate_chg_i) begin
            st_d.cnt = CNT_W'(reload_count(rate_new_i, SLOW_RELOAD));
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign elig_o = (st_q.cnt == '0) && (rate_cur_i != RATE_NEVER);

    // R5
    pace_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_i && rate_new_i != '0) |=> !elig_o);

    // R11
    hold_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (elig_o && !gnt_i && !rate_chg_i) |=> elig_o);

    // R7
    never_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_cur_i == RATE_NEVER) |-> !gnt_i);

endmodule

// File: rtl/gth_rr_pick.sv
module gth_rr_pick #(
    parameter int unsigned N_REQ  = 8,
    localparam int unsigned PTR_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] cand_i,
    output logic [N_REQ-1:0] gnt_o
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } rr_st_t;

    rr_st_t      st_d, st_q;
    logic        found;
    int unsigned win;

    always_comb begin
        st_d  = st_q;
        gnt_o = '0;
        found = 1'b0;
        win   = 0;
        for (int k = 0; k < N_REQ; k++) begin
            int unsigned idx;
            idx = (int'(st_q.ptr) + k) % N_REQ;
            if (!found && cand_i[idx]) begin
                found      = 1'b1;
                win        = idx;
                gnt_o[idx] = 1'b1;
            end
        end
        if (found) st_d.ptr = PTR_W'((win + 1) % N_REQ);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    onehot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R2
    gnt_in_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~cand_i) == '0);

    // R2
    work_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cand_i) |-> (|gnt_o));

endmodule

// File: rtl/gnt_throttle.sv
module gnt_throttle
    import gth_pkg::*;
#(
    parameter int unsigned N_REQ       = 8,
    parameter int unsigned REG_W       = 64,
    parameter int unsigned SLOW_RELOAD = 63,
    localparam int unsigned FIELD_SPAN = N_REQ * RATE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_i,
    input  logic [REG_W-1:0] cfg_data_i,
    input  logic [N_REQ-1:0] req_i,
    input  logic [N_REQ-1:0] byp_gnt_i,
    output logic [N_REQ-1:0] gnt_o,
    output logic [N_REQ-1:0] byp_gnt_o
);

    typedef struct packed {
        logic [FIELD_SPAN-1:0] rates;
    } cfg_st_t;

    cfg_st_t          st_d, st_q;
    logic [N_REQ-1:0] elig;
    logic [N_REQ-1:0] chg;
    logic [N_REQ-1:0] cand;
    logic             unused_hi;

    // reserved upper half of the configuration word
    assign unused_hi = ^cfg_data_i[REG_W-1:FIELD_SPAN];

    always_comb begin
        st_d = st_q;
        if (cfg_wr_i) st_d.rates = cfg_data_i[FIELD_SPAN-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N_REQ; g++) begin : g_unit
        assign chg[g] = cfg_wr_i &&
            (cfg_data_i[g*RATE_W +: RATE_W] != st_q.rates[g*RATE_W +: RATE_W]);

        gth_pace_cnt #(
            .SLOW_RELOAD (SLOW_RELOAD)
        ) pace_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .rate_cur_i (st_q.rates[g*RATE_W +: RATE_W]),
            .rate_new_i (st_d.rates[g*RATE_W +: RATE_W]),
            .rate_chg_i (chg[g]),
            .gnt_i      (gnt_o[g]),
            .elig_o     (elig[g])
        );
    end

    assign cand = req_i & elig;

    gth_rr_pick #(
        .N_REQ (N_REQ)
    ) pick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cand_i (cand),
        .gnt_o  (gnt_o)
    );

    assign byp_gnt_o = byp_gnt_i;

    // R2
    gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~req_i) == '0);

    // R10
    stable_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_i |=> $stable(st_q.rates));

endmodule

// File: tb/gnt_throttle_tb.sv
`timescale 1ns/1ps
module gnt_throttle_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [63:0] cfg_data;
    logic [7:0]  req;
    logic [7:0]  byp_in;
    logic [7:0]  gnt;
    logic [7:0]  byp_out;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    gnt_throttle dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_i   (cfg_wr),
        .cfg_data_i (cfg_data),
        .req_i      (req),
        .byp_gnt_i  (byp_in),
        .gnt_o      (gnt),
        .byp_gnt_o  (byp_out)
    );

    // row: {write, data[63:0], req, bypass in, expected grant}
    localparam int NROW = 19;
    localparam logic [88:0] VEC [NROW] = '{
        {1'b0, 64'h0,                   8'hFF, 8'h00, 8'h01}, // 0  R1 reset search from unit 0
        {1'b0, 64'h0,                   8'hFF, 8'h00, 8'h02}, // 1  R3 rotate
        {1'b0, 64'h0,                   8'h01, 8'h00, 8'h01}, // 2  R6 code 0 again
        {1'b0, 64'h0,                   8'h81, 8'h00, 8'h80}, // 3  R3 pointer at 1
        {1'b0, 64'h0,                   8'h81, 8'h00, 8'h01}, // 4  R3 wrap
        {1'b1, 64'h3,                   8'h00, 8'hA5, 8'h00}, // 5  R9 bypass, R10 write code 3
        {1'b0, 64'h0,                   8'h01, 8'h00, 8'h00}, // 6  R10 counting
        {1'b0, 64'h0,                   8'h01, 8'h00, 8'h00}, // 7  R10
        {1'b0, 64'h0,                   8'h01, 8'h00, 8'h00}, // 8  R10
        {1'b0, 64'h0,                   8'h01, 8'h00, 8'h01}, // 9  R10 eligible
        {1'b0, 64'h0,                   8'h03, 8'h00, 8'h02}, // 10 R5 unit 0 blocked
        {1'b0, 64'h0,                   8'h01, 8'h00, 8'h00}, // 11 R5
        {1'b0, 64'h0,                   8'h00, 8'hFF, 8'h00}, // 12 R9
        {1'b0, 64'h0,                   8'h00, 8'h00, 8'h00}, // 13 R11 idle but eligible
        {1'b0, 64'h0,                   8'h01, 8'h00, 8'h01}, // 14 R11 granted at once
        {1'b1, 64'hFFFF_FFFF_0000_00F0, 8'h02, 8'h00, 8'h02}, // 15 R4 old code still applies
        {1'b0, 64'h0,                   8'h02, 8'h00, 8'h00}, // 16 R7 never
        {1'b0, 64'h0,                   8'h03, 8'h00, 8'h01}, // 17 R4 upper bits ignored
        {1'b1, 64'hE0,                  8'h02, 8'h00, 8'h00}  // 18 R7 still never this cycle
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // count idle cycles before unit mask m is granted
    task automatic wait_grant(input logic [7:0] m, input int exp_idle, input string tag);
        int  idle = 0;
        bit  hit  = 1'b0;
        for (int c = 0; c < 200 && !hit; c++) begin
            @(negedge clk);
            cfg_wr = 1'b0;
            req    = m;
            #1;
            if (gnt == m) hit = 1'b1;
            else          idle++;
        end
        check(tag, 64'(idle), 64'(exp_idle));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_data = '0; req = '0; byp_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 no grant without request", 64'(gnt), 64'h0);
        @(posedge clk);

        for (int r = 0; r < NROW; r++) begin
            @(negedge clk);
            cfg_wr   = VEC[r][88];
            cfg_data = VEC[r][87:24];
            req      = VEC[r][23:16];
            byp_in   = VEC[r][15:8];
            #1;
            check($sformatf("table row %0d grant", r), 64'(gnt), 64'(VEC[r][7:0]));
            check($sformatf("R9 table row %0d bypass", r), 64'(byp_out), 64'(VEC[r][15:8]));
        end

        // R8 slowest code: 63 idle cycles after the write, then after a grant
        wait_grant(8'h02, 63, "R8 first gap");
        wait_grant(8'h02, 63, "R8 gap after grant");

        // R3 full rotation after all codes return to 0; pointer sits at unit 2
        @(negedge clk);
        cfg_wr = 1'b1; cfg_data = 64'h0; req = 8'h00; byp_in = 8'h3C;
        #1;
        check("R9 bypass during write", 64'(byp_out), 64'h3C);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            cfg_wr = 1'b0; req = 8'hFF;
            #1;
            check($sformatf("R3 rotation step %0d", k), 64'(gnt), 64'(8'h01 << ((2 + k) % 8)));
        end

        // R4 top field: unit 7 code 2, R5 spacing
        @(negedge clk);
        cfg_wr = 1'b1; cfg_data = 64'h2000_0000; req = 8'h00;
        #1;
        check("R10 write cycle idle", 64'(gnt), 64'h0);
        wait_grant(8'h80, 2, "R4 R10 unit 7 after write");
        wait_grant(8'h80, 2, "R5 unit 7 after grant");

        // R1 reset mid-run clears codes and pointer
        @(negedge clk);
        rst_n = 1'b0; req = 8'h00;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; req = 8'hFF;
        #1;
        check("R1 pointer after reset", 64'(gnt), 64'h01);
        @(negedge clk);
        req = 8'h80;
        #1;
        check("R1 unit 7 code cleared", 64'(gnt), 64'h80);
        @(negedge clk);
        #1;
        check("R6 unit 7 back to back", 64'(gnt), 64'h80);

        @(negedge clk);
        req = 8'h00;
        finish_run();
    end

endmodule